// File: doc/BRIEF.md
# I2C Slave Receiver with Event Status Codes

This block is a receive-only I2C target. It watches the external SCL and SDA lines through synchronizers. It detects START and STOP conditions and shifts in address and data bytes on the rising edges of SCL. The timing comes entirely from the external clock, so the block has no bit-rate setting.

The block answers when the first byte carries its programmable 7-bit address with the write direction. It can also answer the General Call address, if that response is enabled. Every bus event that concerns the block raises an interrupt flag and loads a status code. Once the block is addressed, each acknowledged byte also holds SCL low until software clears the flag. This gives a software-paced loop: software reads the status code, reads the received byte and decides through the acknowledge-enable bit whether the next byte will be accepted. It then clears the flag to let the bus continue.

Software reaches the block through a small register port with four selects:
- Select 0: write to set control bits, read the control register.
- Select 1: write to clear control bits, read the status register.
- Select 2: read the last received byte.
- Select 3: read and write the own-address register.

The control bits are: enable at bit 6, start request at bit 5, stop request at bit 4, interrupt flag at bit 3 and acknowledge enable at bit 2. The own-address register holds the 7-bit address in bits 7..1 and the General Call enable in bit 0. The block drives a line only by pulling it low: SDA during the acknowledge bit, and SCL while it holds the bus.

Top module: `i2c_srx_top`

## Requirements
- R1: After reset the control register reads 0x00, the own-address register reads 0x00, the status register reads 0xF8, and neither bus line is pulled low.
- R2: A write-direction address byte (R/W bit 0) whose bits 7..1 equal the own address gets an ACK. This needs enable and acknowledge enable both at 1. In the ACK, SDA is low during the ninth SCL high phase. After that clock, the interrupt flag (control bit 3) reads 1 and the status reads 0x60.
- R3: With bits 7..1 of the own-address register at 0x5A and the General Call enable (bit 0) at 1, address byte 0x00 is acknowledged and gives status 0x70. With the General Call enable at 0, address byte 0x00 gets a NACK and the interrupt flag stays 0.
- R4: An address byte that does not match gets a NACK and the interrupt flag stays 0. So does a matching address with R/W bit 1. Later bytes of that transfer also get a NACK.
- R5: While addressed with acknowledge enable at 1, a data byte gets an ACK. The received-data register then holds the byte, and the status reads 0x80 after an own-address match or 0x90 after a General Call.
- R6: When acknowledge enable is cleared during a transfer, the next data byte gets a NACK. The byte is still stored and the status reads 0x88 (own address) or 0x98 (General Call). SCL is not held after this byte. All following bytes get a NACK and leave the interrupt flag at 0 until the next START.
- R7: While acknowledge enable is 0, the own address is not acknowledged and the interrupt flag stays 0. Setting acknowledge enable again makes the next transfer to the own address acknowledged.
- R8: While the interrupt flag is 1 after an ACK, the block holds SCL low. Writing 0x08 to the clear select releases SCL.
- R9: A STOP or a repeated START while addressed sets the interrupt flag with status 0xA0.
- R10: The status register reads 0xF8 whenever the interrupt flag is 0.
- R11: When the hardware sets the interrupt flag in the same cycle that software writes 0x08 to the clear select, the flag ends at 1 and the new status code is kept.
- R12: On a write to the set select, each 1 bit sets that control bit. On a write to the clear select, each 1 bit clears it. Bits written as 0 leave their bit unchanged, and control bits 7, 1 and 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_pull | output | 1 | 1 pulls SCL low (clock hold) |
| sda_pull | output | 1 | 1 pulls SDA low (ACK) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 set/control, 1 clear/status, 2 data, 3 own address) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current select |

## Verification
The hardware setting of the interrupt flag at the end of an acknowledge bit can coincide with a software write that clears the flag. The bench provokes this by counting cycles from the moment its modelled master pulls SCL low at the end of the ninth clock. It counts through the two-stage synchronizer and the edge register and presents the clear write exactly on the edge where the flag is set. The result passes if the flag still reads 1, the status holds 0x60 and SCL is still held, since a lost event would leave the bus released with the idle code.

// File: rtl/i2c_srx_pkg.sv
package i2c_srx_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    localparam logic [7:0] ST_OWN_ACK   = 8'h60;
    localparam logic [7:0] ST_GC_ACK    = 8'h70;
    localparam logic [7:0] ST_OWN_DACK  = 8'h80;
    localparam logic [7:0] ST_OWN_DNACK = 8'h88;
    localparam logic [7:0] ST_GC_DACK   = 8'h90;
    localparam logic [7:0] ST_GC_DNACK  = 8'h98;
    localparam logic [7:0] ST_END       = 8'hA0;
    localparam logic [7:0] ST_IDLE      = 8'hF8;

    localparam int B_EN  = 6;
    localparam int B_STA = 5;
    localparam int B_STO = 4;
    localparam int B_SI  = 3;
    localparam int B_AA  = 2;

    typedef enum logic [3:0] {
        P_IDLE, P_ADDR, P_AACK_PEND, P_AACK, P_HOLD,
        P_DATA, P_DACK_PEND, P_DACK, P_SKIP
    } phase_e;
endpackage

// File: rtl/i2c_srx_sync.sv
module i2c_srx_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] line_i,
    output logic [LINES-1:0] level_o,
    output logic [LINES-1:0] prev_o
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain_q;
        logic              prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= '1;
                prev_q  <= 1'b1;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], line_i[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end
        assign level_o[g] = chain_q[STAGES-1];
        assign prev_o[g]  = prev_q;
    end
endmodule

// File: rtl/i2c_srx_fsm.sv
module i2c_srx_fsm
    import i2c_srx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_s,
    input  logic        scl_p,
    input  logic        sda_s,
    input  logic        sda_p,
    input  logic        en_i,
    input  logic        aa_i,
    input  logic        si_i,
    input  logic [6:0]  own_i,
    input  logic        gc_en_i,
    output logic        si_set_o,
    output logic [7:0]  code_o,
    output logic        data_we_o,
    output logic [7:0]  data_o,
    output logic        sda_pull_o,
    output logic        scl_pull_o
);
    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               gc;
        logic               ack;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    logic scl_rise, scl_fall, start_c, stop_c, addressed;
    logic [BYTE_W-1:0] byte_c;
    logic own_hit, gc_hit;

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_c   = scl_s & scl_p & ~sda_s & sda_p;
    assign stop_c    = scl_s & scl_p & sda_s & ~sda_p;
    assign addressed = (cur_q.ph == P_DATA) || (cur_q.ph == P_DACK_PEND) || (cur_q.ph == P_DACK);
    assign byte_c    = {cur_q.sh[BYTE_W-2:0], sda_s};
    assign own_hit   = (byte_c[7:1] == own_i) && !byte_c[0];
    assign gc_hit    = (byte_c == 8'h00) && gc_en_i;

    always_comb begin
        nxt_d     = cur_q;
        si_set_o  = 1'b0;
        code_o    = ST_IDLE;
        data_we_o = 1'b0;
        if (!en_i) begin
            nxt_d.ph = P_IDLE;
        end else if (start_c) begin
            if (addressed) begin
                si_set_o = 1'b1;
                code_o   = ST_END;
            end
            nxt_d.ph  = P_ADDR;
            nxt_d.cnt = '0;
        end else if (stop_c) begin
            if (addressed) begin
                si_set_o = 1'b1;
                code_o   = ST_END;
            end
            nxt_d.ph = P_IDLE;
        end else begin
            case (cur_q.ph)
                P_ADDR: if (scl_rise) begin
                    nxt_d.sh  = byte_c;
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == CNT_W'(BYTE_W-1)) begin
                        if (aa_i && (own_hit || gc_hit)) begin
                            nxt_d.ph = P_AACK_PEND;
                            nxt_d.gc = !own_hit;
                        end else begin
                            nxt_d.ph = P_SKIP;
                        end
                    end
                end
                P_AACK_PEND: if (scl_fall) nxt_d.ph = P_AACK;
                P_AACK: if (scl_fall) begin
                    si_set_o = 1'b1;
                    code_o   = cur_q.gc ? ST_GC_ACK : ST_OWN_ACK;
                    nxt_d.ph = P_HOLD;
                end
                P_HOLD: if (!si_i) begin
                    nxt_d.ph  = P_DATA;
                    nxt_d.cnt = '0;
                end
                P_DATA: if (scl_rise) begin
                    nxt_d.sh  = byte_c;
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                    if (cur_q.cnt == CNT_W'(BYTE_W-1)) begin
                        nxt_d.ph  = P_DACK_PEND;
                        nxt_d.ack = aa_i;
                    end
                end
                P_DACK_PEND: if (scl_fall) nxt_d.ph = P_DACK;
                P_DACK: if (scl_fall) begin
                    si_set_o  = 1'b1;
                    data_we_o = 1'b1;
                    case ({cur_q.gc, cur_q.ack})
                        2'b01:   code_o = ST_OWN_DACK;
                        2'b00:   code_o = ST_OWN_DNACK;
                        2'b11:   code_o = ST_GC_DACK;
                        default: code_o = ST_GC_DNACK;
                    endcase
                    nxt_d.ph = cur_q.ack ? P_HOLD : P_SKIP;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{ph: P_IDLE, cnt: '0, sh: '0, gc: 1'b0, ack: 1'b0};
        else        cur_q <= nxt_d;
    end

    assign data_o     = cur_q.sh;
    assign sda_pull_o = (cur_q.ph == P_AACK) || ((cur_q.ph == P_DACK) && cur_q.ack);
    assign scl_pull_o = (cur_q.ph == P_HOLD) && si_i;

    AST_ACK_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull_o) |-> !scl_s);  // R2
    AST_NO_ADDR_ACK_WITHOUT_AA: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph == P_ADDR && scl_rise && !start_c && !stop_c && en_i && !aa_i
         && cur_q.cnt == CNT_W'(BYTE_W-1)) |=> (cur_q.ph == P_SKIP));  // R7
    AST_NACK_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph == P_DACK_PEND && !cur_q.ack) |=> !sda_pull_o);  // R6
endmodule

// File: rtl/i2c_srx_regs.sv
module i2c_srx_regs
    import i2c_srx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        si_set_i,
    input  logic [7:0]  code_i,
    input  logic        data_we_i,
    input  logic [7:0]  data_i,
    output logic        en_o,
    output logic        aa_o,
    output logic        si_o,
    output logic [6:0]  own_o,
    output logic        gc_en_o
);
    localparam logic [7:0] CTRL_MASK = 8'h7C;

    typedef struct packed {
        logic [7:0] ctrl;
        logic [7:0] own;
        logic [7:0] stat;
        logic [7:0] rx;
    } regs_t;

    regs_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (reg_wr) begin
            case (reg_sel)
                2'd0: r_d.ctrl = r_q.ctrl | (reg_wdata & CTRL_MASK);
                2'd1: r_d.ctrl = r_q.ctrl & ~(reg_wdata & CTRL_MASK);
                2'd3: r_d.own  = reg_wdata;
                default: ;
            endcase
        end
        if (si_set_i) begin
            r_d.ctrl[B_SI] = 1'b1;
            r_d.stat       = code_i;
        end
        if (data_we_i) r_d.rx = data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{ctrl: 8'h00, own: 8'h00, stat: ST_IDLE, rx: 8'h00};
        else        r_q <= r_d;
    end

    always_comb begin
        case (reg_sel)
            2'd0:    reg_rdata = r_q.ctrl;
            2'd1:    reg_rdata = r_q.ctrl[B_SI] ? r_q.stat : ST_IDLE;
            2'd2:    reg_rdata = r_q.rx;
            default: reg_rdata = r_q.own;
        endcase
    end

    assign en_o    = r_q.ctrl[B_EN];
    assign aa_o    = r_q.ctrl[B_AA];
    assign si_o    = r_q.ctrl[B_SI];
    assign own_o   = r_q.own[7:1];
    assign gc_en_o = r_q.own[0];

    AST_SI_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        si_set_i |=> si_o);  // R11
    AST_UNUSED_CTRL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == 2'd0) |=> (r_q.ctrl[7] == 1'b0 && r_q.ctrl[1:0] == 2'b00));  // R12
endmodule

// File: rtl/i2c_srx_top.sv
module i2c_srx_top
    import i2c_srx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pull,
    output logic       sda_pull,
    input  logic       reg_wr,
    input  logic [1:0] reg_sel,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata
);
    logic [1:0] lvl, prv;
    logic en, aa, si, gc_en, si_set, data_we;
    logic [6:0] own;
    logic [7:0] code, rx_byte;

    i2c_srx_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .line_i({scl_i, sda_i}),
        .level_o(lvl), .prev_o(prv)
    );

    i2c_srx_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .scl_s(lvl[1]), .scl_p(prv[1]), .sda_s(lvl[0]), .sda_p(prv[0]),
        .en_i(en), .aa_i(aa), .si_i(si), .own_i(own), .gc_en_i(gc_en),
        .si_set_o(si_set), .code_o(code), .data_we_o(data_we), .data_o(rx_byte),
        .sda_pull_o(sda_pull), .scl_pull_o(scl_pull)
    );

    i2c_srx_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .si_set_i(si_set), .code_i(code), .data_we_i(data_we), .data_i(rx_byte),
        .en_o(en), .aa_o(aa), .si_o(si), .own_o(own), .gc_en_o(gc_en)
    );

    AST_HOLD_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(sda_pull));  // R8
    AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(si) |-> !scl_pull);  // R8
endmodule

// File: tb/i2c_srx_top_bench.sv
module i2c_srx_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int QW = 6;
    localparam int HW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic scl_pull, sda_pull;
    wire scl_bus = scl_m & ~scl_pull;
    wire sda_bus = sda_m & ~sda_pull;

    int n_chk = 0, n_fail = 0;
    logic ack_slot = 1'b0;
    logic exp_q[$];
    int   req_q[$];
    bit   done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_srx_top u_i2c_srx_top (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [7:0] val);
        @(negedge clk);
        reg_sel = sel;
        #1 val = reg_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [1:0] sel, input logic [7:0] exp);
        logic [7:0] v;
        rd(sel, v);
        check(req, v, exp);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wclk(QW);
        scl_m = 1'b1;
        wait (scl_bus === 1'b1);
        wclk(HW);
        scl_m = 1'b0; wclk(QW);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wclk(QW);
        scl_m = 1'b1; wclk(QW);
        sda_m = 1'b0; wclk(QW);
        scl_m = 1'b0; wclk(QW);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wclk(QW);
        scl_m = 1'b1; wclk(QW);
        sda_m = 1'b1; wclk(QW);
    endtask

    // driver: sends a byte and pushes the expected SDA level of the ACK slot
    task automatic send_byte(input logic [7:0] b, input logic exp_sda, input int rnum, input bit race);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        exp_q.push_back(exp_sda);
        req_q.push_back(rnum);
        sda_m = 1'b1; ack_slot = 1'b1; wclk(QW);
        scl_m = 1'b1;
        wait (scl_bus === 1'b1);
        wclk(HW);
        scl_m = 1'b0; ack_slot = 1'b0;
        if (race) begin
            @(posedge clk); @(posedge clk);
            @(negedge clk);
            reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h08;
            @(posedge clk);
            @(negedge clk);
            reg_wr = 1'b0;
            wclk(QW);
        end else begin
            wclk(QW);
        end
    endtask

    // monitor: pops the expected ACK level and compares with the bus
    initial begin
        forever begin
            @(posedge scl_bus);
            if (ack_slot) begin
                logic e; int r;
                wclk(3);
                if (exp_q.size() == 0) begin
                    n_chk++; n_fail++;
                    $display("FAIL ack monitor: actual %0b expected none", sda_bus);
                end else begin
                    e = exp_q.pop_front(); r = req_q.pop_front();
                    check($sformatf("R%0d ack level", r), {7'd0, sda_bus}, {7'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        wclk(3);
        rst_n = 1'b1;
        wclk(2);
        // R1 / R10
        chk_reg("R1 ctrl", 2'd0, 8'h00);
        chk_reg("R1 own", 2'd3, 8'h00);
        chk_reg("R10 idle status", 2'd1, 8'hF8);
        check("R1 pulls", {6'd0, scl_pull, sda_pull}, 8'h00);

        // R12
        wr(2'd3, 8'hB5);
        wr(2'd0, 8'h44);
        wr(2'd0, 8'h83);
        chk_reg("R12 set ignores unused", 2'd0, 8'h44);
        wr(2'd0, 8'h30);
        wr(2'd1, 8'h30);
        wr(2'd1, 8'h00);
        chk_reg("R12 clear", 2'd0, 8'h44);

        // own address transfer
        bus_start();
        send_byte(8'hB4, 1'b0, 2, 0);
        chk_reg("R2 flag", 2'd0, 8'h4C);
        chk_reg("R2 status", 2'd1, 8'h60);
        wclk(20);
        check("R8 scl held", {7'd0, scl_pull}, 8'h01);
        wr(2'd1, 8'h08);
        wclk(2);
        check("R8 scl released", {7'd0, scl_pull}, 8'h00);
        chk_reg("R10 status after clear", 2'd1, 8'hF8);
        send_byte(8'h3C, 1'b0, 5, 0);
        chk_reg("R5 status own", 2'd1, 8'h80);
        chk_reg("R5 data", 2'd2, 8'h3C);
        wr(2'd1, 8'h04);
        wr(2'd1, 8'h08);
        send_byte(8'hC3, 1'b1, 6, 0);
        chk_reg("R6 status own nack", 2'd1, 8'h88);
        chk_reg("R6 data kept", 2'd2, 8'hC3);
        check("R6 no hold", {7'd0, scl_pull}, 8'h00);
        wr(2'd1, 8'h08);
        wr(2'd0, 8'h04);
        send_byte(8'h11, 1'b1, 6, 0);
        chk_reg("R6 later byte flag", 2'd0, 8'h44);
        chk_reg("R6 later byte data", 2'd2, 8'hC3);
        bus_stop();

        // General Call transfer
        bus_start();
        send_byte(8'h00, 1'b0, 3, 0);
        chk_reg("R3 gc status", 2'd1, 8'h70);
        wr(2'd1, 8'h08);
        send_byte(8'h5E, 1'b0, 5, 0);
        chk_reg("R5 status gc", 2'd1, 8'h90);
        wr(2'd1, 8'h04);
        wr(2'd1, 8'h08);
        send_byte(8'h01, 1'b1, 6, 0);
        chk_reg("R6 status gc nack", 2'd1, 8'h98);
        wr(2'd1, 8'h08);
        bus_stop();
        wr(2'd0, 8'h04);

        // mismatch and read direction
        bus_start();
        send_byte(8'hB6, 1'b1, 4, 0);
        send_byte(8'hFF, 1'b1, 4, 0);
        chk_reg("R4 mismatch flag", 2'd0, 8'h44);
        bus_stop();
        bus_start();
        send_byte(8'hB5, 1'b1, 4, 0);
        chk_reg("R4 read dir flag", 2'd0, 8'h44);
        bus_stop();

        // acknowledge enable off then on
        wr(2'd1, 8'h04);
        bus_start();
        send_byte(8'hB4, 1'b1, 7, 0);
        chk_reg("R7 no flag", 2'd0, 8'h40);
        bus_stop();
        wr(2'd0, 8'h04);
        bus_start();
        send_byte(8'hB4, 1'b0, 7, 0);
        chk_reg("R7 resumed", 2'd1, 8'h60);
        wr(2'd1, 8'h08);
        send_byte(8'h77, 1'b0, 5, 0);
        wr(2'd1, 8'h08);
        bus_stop();
        wclk(4);
        chk_reg("R9 stop status", 2'd1, 8'hA0);
        wr(2'd1, 8'h08);

        // repeated start
        bus_start();
        send_byte(8'hB4, 1'b0, 2, 0);
        wr(2'd1, 8'h08);
        bus_start();
        chk_reg("R9 rstart status", 2'd1, 8'hA0);
        wr(2'd1, 8'h08);
        send_byte(8'hB4, 1'b0, 2, 0);
        chk_reg("R2 after rstart", 2'd1, 8'h60);
        wr(2'd1, 8'h08);
        bus_stop();
        wr(2'd1, 8'h08);

        // General Call disabled
        wr(2'd3, 8'hB4);
        bus_start();
        send_byte(8'h00, 1'b1, 3, 0);
        chk_reg("R3 gc disabled flag", 2'd0, 8'h44);
        bus_stop();

        // R11: hardware set and software clear in the same cycle
        bus_start();
        send_byte(8'hB4, 1'b0, 11, 1);
        chk_reg("R11 flag kept", 2'd0, 8'h4C);
        chk_reg("R11 status kept", 2'd1, 8'h60);
        check("R11 scl held", {7'd0, scl_pull}, 8'h01);
        wr(2'd1, 8'h08);
        bus_stop();
        wclk(10);

        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL ack monitor: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule